// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block produces one pulse-width-modulated output from an 8-bit timebase. The timebase is clocked through a selectable input prescaler and wraps when it reaches an 8-bit period value. Every timer step is divided into four fine phases. Together they form a 10-bit count, and this count is compared with a 10-bit duty value. The output rises at the start of each period. It falls when the 10-bit count reaches the active duty.

Software writes the duty as an upper byte plus two low bits in the mode register. These writes land in holding registers only. The active duty sits in a separate shadow latch, and that latch is reloaded only when the timer wraps. A duty change therefore never shortens or stretches a pulse that is already under way.

The block also gives a single-cycle period-match pulse on every wrap. A postscaled event pulse fires once every 1 to 16 wraps.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After reset, `pwm_out`, `period_hit` and `tmr_evt` are low, the period register holds 0xFF and the timer holds 0. Enabling the timer with prescale 1 and nothing else written gives the first `period_hit` 1024 clocks after the enabling write.
- R2: The write map has four registers:
  - Address 0 is the period.
  - Address 1 holds duty bits [9:2].
  - Address 2 holds duty bits [1:0] in data bits [5:4] and the mode in data bits [3:0].
  - Address 3 is timer control: postscale in [6:3], timer-on in [2], prescale in [1:0]. Data bit 7 of this register is ignored.
- R3: Prescale code 00 selects a ratio of 1, code 01 selects 4, and 1x selects 16. A period lasts (P+1)·4·ratio clocks. The timer does not advance while timer-on is 0.
- R4: `period_hit` is a one-clock pulse on each wrap. It is high in the same cycle as the rising edge of the output.
- R5: With duty D between 1 and (P+1)·4−1, `pwm_out` is high for exactly D·ratio clocks per period.
- R6: A duty of 0 keeps `pwm_out` low for the whole period.
- R7: A duty of (P+1)·4 or more keeps `pwm_out` high for the whole period.
- R8: A duty written in mid-period does not change the current pulse. It takes effect from the next wrap.
- R9: PWM is active only when mode bits [3:2] are 11. With any other mode value, `pwm_out` is low from the clock after the mode write, while the timer and `period_hit` keep running.
- R10: With postscale field n, `tmr_evt` is a one-clock pulse that is coincident with every (n+1)-th `period_hit`. A timer-control write restarts both the prescale phase and the postscale count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one prescaler input step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| period_hit | output | 1 | One-cycle pulse on each timer wrap |
| tmr_evt | output | 1 | Postscaled wrap event pulse |

## Verification
The hardest case to reach from the ports is a duty change that arrives while a pulse is in flight. The holding registers must differ from the shadow for part of one period, and the old value must still end that pulse. The bench measures a period with one duty. Three clocks after the wrap, and well before the fall, it writes both duty registers from inside the measuring loop. It then checks that this period keeps the old high time and that the following period shows the new one. A duty larger than the reachable count is also set, to show that the output never falls.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;
  localparam logic [1:0] ADDR_TCTL   = 2'd3;

  // log2 of the prescale ratio for a prescale code: 1, 4, 16
  function automatic int pre_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  // PWM is selected by mode bits [3:2] == 11
  function automatic logic is_pwm(input logic [3:0] mode);
    return mode[3:2] == 2'b11;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2,
  parameter int POST_W = 4,
  localparam int DUTY_W = TMR_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [TMR_W-1:0]  period_q,
  output logic [DUTY_W-1:0] duty_wr,
  output logic [3:0]        mode_q,
  output logic [POST_W-1:0] post_sel,
  output logic              tmr_on,
  output logic [1:0]        pre_sel,
  output logic              tctl_wr
);
  logic [TMR_W-1:0]  duty_hi_q;
  logic [FINE_W-1:0] duty_lo_q;

  assign tctl_wr = wr_en && (wr_addr == ADDR_TCTL);
  assign duty_wr = {duty_hi_q, duty_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q  <= '1;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      mode_q    <= '0;
      post_sel  <= '0;
      tmr_on    <= 1'b0;
      pre_sel   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD: period_q  <= wr_data[TMR_W-1:0];
        ADDR_DUTY:   duty_hi_q <= wr_data[TMR_W-1:0];
        ADDR_MODE: begin
          duty_lo_q <= wr_data[4 +: FINE_W];
          mode_q    <= wr_data[3:0];
        end
        default: begin
          post_sel <= wr_data[3 +: POST_W];
          tmr_on   <= wr_data[2];
          pre_sel  <= wr_data[1:0];
        end
      endcase
    end
  end

  a_r2_reset_period: assert property (@(posedge clk)
    $rose(rst_n) |-> (period_q == '1));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int FINE_W      = 2,
  parameter int POST_W      = 4,
  parameter int PRE_LOG_MAX = 4,
  localparam int DUTY_W = TMR_W + FINE_W,
  localparam int SUB_W  = FINE_W + PRE_LOG_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_on,
  input  logic [1:0]        pre_sel,
  input  logic [POST_W-1:0] post_sel,
  input  logic [TMR_W-1:0]  period,
  input  logic              restart,
  output logic [DUTY_W-1:0] nxt_cnt,
  output logic              wrap,
  output logic              period_hit,
  output logic              tmr_evt
);
  logic [SUB_W-1:0]  sub_q, sub_nxt, sub_last;
  logic [TMR_W-1:0]  timer_q, timer_nxt;
  logic [POST_W-1:0] post_q;
  logic              tick;

  // one timer step spans 4 * ratio input clocks
  assign sub_last = SUB_W'((1 << (FINE_W + pre_shift(pre_sel))) - 1);
  assign tick     = tmr_on && !restart && (sub_q == sub_last);
  assign wrap     = tick && (timer_q == period);

  always_comb begin
    if (restart)      sub_nxt = '0;
    else if (!tmr_on) sub_nxt = sub_q;
    else if (tick)    sub_nxt = '0;
    else              sub_nxt = sub_q + 1'b1;
    if (wrap)         timer_nxt = '0;
    else if (tick)    timer_nxt = timer_q + 1'b1;
    else              timer_nxt = timer_q;
  end

  // count the output stage will hold after this edge
  assign nxt_cnt = {timer_nxt, FINE_W'(sub_nxt >> pre_shift(pre_sel))};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q      <= '0;
      timer_q    <= '0;
      post_q     <= '0;
      period_hit <= 1'b0;
      tmr_evt    <= 1'b0;
    end else begin
      sub_q      <= sub_nxt;
      timer_q    <= timer_nxt;
      period_hit <= wrap;
      tmr_evt    <= wrap && (post_q == post_sel);
      if (restart)   post_q <= '0;
      else if (wrap) post_q <= (post_q == post_sel) ? '0 : post_q + 1'b1;
    end
  end

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_on |=> $stable(timer_q));
  a_r4_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> !period_hit);
  a_r10_evt_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |-> period_hit);

endmodule

// File: rtl/pwm_duty_out.sv
module pwm_duty_out #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_en,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] duty_wr,
  input  logic [DUTY_W-1:0] nxt_cnt,
  output logic              pin_q
);
  logic [DUTY_W-1:0] shadow_q;
  logic              duty_hit;

  assign duty_hit = (nxt_cnt == shadow_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pin_q    <= 1'b0;
    end else begin
      if (wrap) shadow_q <= duty_wr;
      if (!pwm_en)       pin_q <= 1'b0;
      else if (wrap)     pin_q <= (duty_wr != '0);
      else if (duty_hit) pin_q <= 1'b0;
    end
  end

  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(shadow_q));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> !pin_q);
  a_r5_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_q) |-> $past(wrap));
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && duty_wr == '0) |=> !pin_q);

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int FINE_W      = 2,
  parameter int POST_W      = 4,
  parameter int PRE_LOG_MAX = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pwm_out,
  output logic       period_hit,
  output logic       tmr_evt
);
  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  period_q;
  logic [DUTY_W-1:0] duty_wr, nxt_cnt;
  logic [3:0]        mode_q;
  logic [POST_W-1:0] post_sel;
  logic [1:0]        pre_sel;
  logic              tmr_on, tctl_wr, wrap, pwm_en;

  assign pwm_en = is_pwm(mode_q);

  pwm_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W), .POST_W(POST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period_q(period_q), .duty_wr(duty_wr),
    .mode_q(mode_q), .post_sel(post_sel), .tmr_on(tmr_on),
    .pre_sel(pre_sel), .tctl_wr(tctl_wr)
  );

  pwm_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W), .POST_W(POST_W),
                 .PRE_LOG_MAX(PRE_LOG_MAX)) u_tb (
    .clk(clk), .rst_n(rst_n), .tmr_on(tmr_on), .pre_sel(pre_sel),
    .post_sel(post_sel), .period(period_q), .restart(tctl_wr),
    .nxt_cnt(nxt_cnt), .wrap(wrap), .period_hit(period_hit),
    .tmr_evt(tmr_evt)
  );

  pwm_duty_out #(.DUTY_W(DUTY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .wrap(wrap),
    .duty_wr(duty_wr), .nxt_cnt(nxt_cnt), .pin_q(pwm_out)
  );

  a_r4_rise_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> period_hit);

endmodule

// File: tb/tb_pwm_dbuf_gen.sv
module tb_pwm_dbuf_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, period_hit, tmr_evt;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  pwm_dbuf_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .period_hit(period_hit),
    .tmr_evt(tmr_evt)
  );

  // {prescale code, period, duty, expected high clocks, expected period clocks}
  localparam int NV = 7;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, 8'd9,   10'd13,   16'd13,   16'd40},
    {2'd1, 8'd4,   10'd7,    16'd28,   16'd80},
    {2'd2, 8'd2,   10'd5,    16'd80,   16'd192},
    {2'd0, 8'd15,  10'd63,   16'd63,   16'd64},
    {2'd0, 8'd7,   10'd1,    16'd1,    16'd32},
    {2'd3, 8'd1,   10'd3,    16'd48,   16'd128},
    {2'd0, 8'd255, 10'd1000, 16'd1000, 16'd1024}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_duty(input logic [9:0] d, input logic [3:0] mode);
    wr(2'd1, d[9:2]);
    wr(2'd2, {2'b00, d[1:0], mode});
  endtask

  task automatic wait_hit();
    @(negedge clk);
    while (!period_hit) @(negedge clk);
  endtask

  // called at a negedge where period_hit is high; ends at the next one
  task automatic measure(output int hi, output int per,
                         input bit mid_wr, input logic [9:0] nd);
    int n = 0;
    hi = 0;
    do begin
      if (pwm_out) hi++;
      n++;
      if (mid_wr && n == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = nd[9:2]; end
      if (mid_wr && n == 4) begin wr_addr = 2'd2; wr_data = {2'b00, nd[1:0], 4'b1100}; end
      if (mid_wr && n == 5) wr_en = 1'b0;
      @(negedge clk);
    end while (!period_hit);
    per = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, n, cnt, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of the outputs
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 period_hit after reset", int'(period_hit), 0);
    chk("R1 tmr_evt after reset", int'(tmr_evt), 0);
    // R1/R3: default period 0xFF, ratio 1 -> first wrap after 1024 clocks
    wr(2'd3, 8'h04);
    n = 0; hi = 0;
    do begin @(negedge clk); n++; if (pwm_out) hi++; end while (!period_hit);
    chk("R1 first hit after default period", n, 1024);
    chk("R9 mode 0 keeps output low", hi, 0);
    @(negedge clk);
    chk("R4 period_hit lasts one clock", int'(period_hit), 0);

    // R5/R3/R2: vector table
    for (int i = 0; i < NV; i++) begin
      logic [51:0] v = VEC[i];
      wr(2'd3, {5'b00000, 1'b1, v[51:50]});
      wr(2'd0, v[49:42]);
      set_duty(v[41:32], 4'b1100);
      wait_hit();
      chk("R4 output rises with period_hit", int'(pwm_out), int'(v[41:32] != 0));
      measure(hi, per, 1'b0, '0);
      chk($sformatf("R5 high time vector %0d", i), hi, int'(v[31:16]));
      chk($sformatf("R3 period vector %0d", i), per, int'(v[15:0]));
    end

    // R8: mid-period duty write waits for the next wrap
    wr(2'd3, 8'h04);
    wr(2'd0, 8'd9);
    set_duty(10'd8, 4'b1100);
    wait_hit();
    measure(hi, per, 1'b0, '0);
    chk("R5 duty 8 before update", hi, 8);
    measure(hi, per, 1'b1, 10'd20);
    chk("R8 current period keeps old duty", hi, 8);
    measure(hi, per, 1'b0, '0);
    chk("R8 next period uses new duty", hi, 20);

    // R6: duty zero
    set_duty(10'd0, 4'b1100);
    wait_hit();
    measure(hi, per, 1'b0, '0);
    chk("R6 duty zero high time", hi, 0);
    chk("R6 duty zero period", per, 40);

    // R7: duty beyond reachable count, P=3 -> max count 15
    wr(2'd0, 8'd3);
    set_duty(10'd20, 4'b1100);
    wait_hit();
    measure(hi, per, 1'b0, '0);
    chk("R7 oversized duty period", per, 16);
    chk("R7 oversized duty stays high", hi, 16);

    // R9: non-PWM modes silence the output, timer keeps running
    wr(2'd0, 8'd9);
    set_duty(10'd13, 4'b1100);
    wait_hit();
    wr(2'd2, {2'b00, 2'b01, 4'b1000});
    hi = 0; cnt = 0;
    repeat (100) begin @(negedge clk); if (pwm_out) hi++; if (period_hit) cnt++; end
    chk("R9 mode 1000 output low", hi, 0);
    chk("R9 wraps continue without PWM", int'(cnt >= 2), 1);
    wr(2'd2, {2'b00, 2'b01, 4'b1110});
    wait_hit();
    measure(hi, per, 1'b0, '0);
    chk("R9 mode 1110 restores PWM", hi, 13);

    // R3: timer off -> no wraps
    wr(2'd3, 8'h00);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (period_hit) cnt++; end
    chk("R3 timer off no wraps", cnt, 0);

    // R10: postscale 2 -> event every third wrap
    wr(2'd0, 8'd1);
    wr(2'd3, {1'b0, 4'd2, 1'b1, 2'b00});
    @(negedge clk);
    while (!tmr_evt) @(negedge clk);
    cnt = 0; bad = 0;
    do begin
      @(negedge clk);
      if (period_hit) cnt++;
      if (tmr_evt && !period_hit) bad++;
    end while (!tmr_evt);
    chk("R10 wraps per event with postscale 2", cnt, 3);
    chk("R10 event only with period_hit", bad, 0);

    // R2: bit 7 of timer control ignored -> postscale 0, ratio 1
    wr(2'd3, 8'h84);
    wait_hit();
    chk("R2 bit 7 ignored, event every wrap", int'(tmr_evt), 1);
    measure(hi, per, 1'b0, '0);
    chk("R2 bit 7 ignored, period length", per, 8);
    chk("R10 event on next wrap too", int'(tmr_evt), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule